// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits beside the data cache of one hart and tracks a single load-reserved reservation. Each cycle it may take one request (load-reserved, store-conditional, plain store or atomic memory operation) with an address, an access size and write data. It also watches a snoop port that reports stores made by other harts. For every store-conditional it decides success or failure. It lets the memory write through only on success and returns a status word one cycle later.

The reservation lives in a two-state machine. In `RSV_EMPTY` no reservation is held. In `RSV_HELD` a granule-aligned address is recorded.

The transitions are:
- **T_ARM**: a load-reserved moves `RSV_EMPTY` to `RSV_HELD`.
- **T_REARM**: a load-reserved in `RSV_HELD` stays in `RSV_HELD` and overwrites the recorded granule.
- **T_CONSUME**: any store-conditional moves `RSV_HELD` to `RSV_EMPTY`, whether it succeeds or fails.
- **T_SNOOP_KILL**: a remote store to the recorded granule moves `RSV_HELD` to `RSV_EMPTY`.
- **T_FLUSH**: the clear input, used on traps and context switches, forces `RSV_EMPTY` from either state.

Because every store-conditional consumes the reservation, the sequence LR A, SC B, SC A fails twice.

Top module: `resv_monitor`

## Requirements
- R1: After reset, or whenever no reservation is held, a store-conditional fails. Its status is 1 and no memory write is issued. Right after reset, `rsp_valid_o` and `mem_we_o` are 0.
- R2: A load-reserved records the address granule (address bits 31 down to 3, an 8-byte granule). A later store-conditional to the same granule, with no intervening event, succeeds. Its status is 0 and the write is issued, both one cycle after the request.
- R3: A store-conditional whose granule differs from the recorded one fails and issues no write.
- R4: Every store-conditional, successful or not, ends the reservation. For LR A, SC B, SC A, both store-conditionals fail.
- R5: A snoop store whose granule matches the recorded granule ends the reservation, so a later store-conditional fails. A snoop to another granule has no effect. A load-reserved in the same cycle as a snoop takes precedence, so the new reservation is kept.
- R6: If a matching snoop arrives in the same cycle as a store-conditional to the reserved granule, the store-conditional fails.
- R7: A new load-reserved replaces the existing reservation. For LR A, LR B, an SC A fails, while an SC B succeeds.
- R8: `rsp_valid_o` is high for exactly the cycle after each store-conditional request and at no other time. `rsp_status_o` is 0 on success and 1 on failure.
- R9: Memory writes follow the access size. `req_size_i`=1 (8 bytes) gives byte enables 0xFF. `req_size_i`=0 (4 bytes) gives 0x0F when address bit 2 is 0 and 0xF0 when it is 1, with the low 32 data bits copied into both halves of `mem_wdata_o`. `mem_addr_o` is the request address with bits 2:0 cleared. A failed store-conditional never asserts `mem_we_o`.
- R10: Plain stores (op 2) and AMOs (op 3) always write and leave the reservation untouched. Ops are encoded 0 = load-reserved, 1 = store-conditional.
- R11: `clr_i` ends the reservation and wins over a load-reserved in the same cycle. A store-conditional in the same cycle as `clr_i` fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Drop any reservation (trap, context switch) |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 load-reserved, 1 store-conditional, 2 store, 3 AMO |
| req_addr_i | input | 32 | Byte address of the request |
| req_size_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_wdata_i | input | 64 | Store data |
| snoop_valid_i | input | 1 | A remote hart stored this cycle |
| snoop_addr_i | input | 32 | Byte address of the remote store |
| rsp_valid_o | output | 1 | Store-conditional result valid |
| rsp_status_o | output | 64 | 0 success, 1 failure |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 8 | Byte enables |
| mem_addr_o | output | 32 | Word-aligned write address |
| mem_wdata_o | output | 64 | Lane-positioned write data |

## Verification
The bench uses the default parameters: 32-bit addresses, 64-bit data and an 8-byte granule. It draws random addresses from only four neighbouring granules, so store-conditional hits, misses, snoop matches and same-cycle races all occur often. With a 4-byte half-word, random 4-byte accesses land on both byte-enable lanes of the same granule. Directed sequences cover the double-failure case, reservation replacement and the clear-versus-load-reserved tie.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        OP_LR  = 2'd0,
        OP_SC  = 2'd1,
        OP_ST  = 2'd2,
        OP_AMO = 2'd3
    } resv_op_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } resv_state_e;
endpackage

// File: rtl/resv_granule_match.sv
module resv_granule_match #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 3
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    output logic              hit_o
);
    localparam int TAG_W = ADDR_W - GRAN_LG2;

    logic [TAG_W-1:0] tag_a;
    logic [TAG_W-1:0] tag_b;

    assign tag_a = a_i[ADDR_W-1:GRAN_LG2];
    assign tag_b = b_i[ADDR_W-1:GRAN_LG2];
    assign hit_o = (tag_a == tag_b);
endmodule

// File: rtl/resv_fsm.sv
module resv_fsm
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              lr_i,
    input  logic              sc_i,
    input  logic              snoop_hit_i,
    input  logic [ADDR_W-1:0] lr_addr_i,
    output logic              held_o,
    output logic [ADDR_W-1:0] rsv_addr_o
);
    localparam int TAG_W = ADDR_W - GRAN_LG2;

    resv_state_e      state_q, state_d;
    logic             load_tag;
    logic [TAG_W-1:0] tag_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_tag) tag_q <= lr_addr_i[ADDR_W-1:GRAN_LG2];
        end
    end

    // transitions: T_FLUSH, T_ARM, T_REARM, T_CONSUME, T_SNOOP_KILL
    always_comb begin
        state_d  = state_q;
        load_tag = 1'b0;
        if (clr_i) begin
            state_d = RSV_EMPTY;                       // T_FLUSH
        end else begin
            unique case (state_q)
                RSV_EMPTY: begin
                    if (lr_i) begin
                        state_d  = RSV_HELD;           // T_ARM
                        load_tag = 1'b1;
                    end
                end
                RSV_HELD: begin
                    if (lr_i) begin
                        load_tag = 1'b1;               // T_REARM
                    end else if (sc_i || snoop_hit_i) begin
                        state_d = RSV_EMPTY;           // T_CONSUME / T_SNOOP_KILL
                    end
                end
                default: state_d = RSV_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        held_o     = (state_q == RSV_HELD);
        rsv_addr_o = {tag_q, {GRAN_LG2{1'b0}}};
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !held_o);                                                  // R11
    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_i && !lr_i) |=> !held_o);                                        // R4
    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit_i && !lr_i) |=> !held_o);                                 // R5
    AST_LR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_i && !clr_i) |=> (held_o &&
            rsv_addr_o[ADDR_W-1:GRAN_LG2] == $past(lr_addr_i[ADDR_W-1:GRAN_LG2]))); // R7
endmodule

// File: rtl/resv_write_gate.sv
module resv_write_gate #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_sc_i,
    input  logic              sc_ok_i,
    input  logic              plain_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              full_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_status_o,
    output logic              mem_we_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int BE_W   = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int HBE_W  = BE_W / 2;
    localparam int OFF_W  = $clog2(BE_W);

    logic              we_d;
    logic [BE_W-1:0]   be_d;
    logic [DATA_W-1:0] data_d;

    always_comb begin
        we_d = plain_wr_i || (is_sc_i && sc_ok_i);
        if (full_i) begin
            be_d   = '1;
            data_d = wdata_i;
        end else begin
            be_d   = addr_i[OFF_W-1] ? {{HBE_W{1'b1}}, {HBE_W{1'b0}}}
                                     : {{HBE_W{1'b0}}, {HBE_W{1'b1}}};
            data_d = {wdata_i[HALF_W-1:0], wdata_i[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            rsp_status_o <= '0;
            mem_we_o     <= 1'b0;
            mem_be_o     <= '0;
            mem_addr_o   <= '0;
            mem_wdata_o  <= '0;
        end else begin
            rsp_valid_o  <= is_sc_i;
            rsp_status_o <= {{(DATA_W-1){1'b0}}, is_sc_i && !sc_ok_i};
            mem_we_o     <= we_d;
            mem_be_o     <= we_d ? be_d : '0;
            mem_addr_o   <= {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            mem_wdata_o  <= data_d;
        end
    end

    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o[0]) |-> !mem_we_o);                    // R9
    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($countones(mem_be_o) == BE_W || $countones(mem_be_o) == HBE_W)); // R9
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 64,
    parameter int GRAN_LG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                req_valid_i,
    input  logic [1:0]          req_op_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                req_size_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    input  logic                snoop_valid_i,
    input  logic [ADDR_W-1:0]   snoop_addr_i,
    output logic                rsp_valid_o,
    output logic [DATA_W-1:0]   rsp_status_o,
    output logic                mem_we_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [DATA_W-1:0]   mem_wdata_o
);
    resv_op_e          op;
    logic              is_lr, is_sc, is_wr;
    logic              held;
    logic [ADDR_W-1:0] rsv_addr;
    logic              sc_hit, snoop_tag_hit, snoop_hit, sc_ok;

    assign op    = resv_op_e'(req_op_i);
    assign is_lr = req_valid_i && (op == OP_LR);
    assign is_sc = req_valid_i && (op == OP_SC);
    assign is_wr = req_valid_i && (op == OP_ST || op == OP_AMO);

    resv_granule_match #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_sc_match (
        .a_i(req_addr_i), .b_i(rsv_addr), .hit_o(sc_hit));

    resv_granule_match #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_snoop_match (
        .a_i(snoop_addr_i), .b_i(rsv_addr), .hit_o(snoop_tag_hit));

    assign snoop_hit = snoop_valid_i && held && snoop_tag_hit;
    assign sc_ok     = is_sc && held && sc_hit && !snoop_hit && !clr_i;

    resv_fsm #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .lr_i(is_lr), .sc_i(is_sc),
        .snoop_hit_i(snoop_hit), .lr_addr_i(req_addr_i),
        .held_o(held), .rsv_addr_o(rsv_addr));

    resv_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .is_sc_i(is_sc), .sc_ok_i(sc_ok),
        .plain_wr_i(is_wr), .addr_i(req_addr_i), .full_i(req_size_i),
        .wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
        .rsp_status_o(rsp_status_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

    AST_SC_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc |=> rsp_valid_o);                                              // R8
    AST_RSP_FROM_SC: assert property (@(posedge clk) disable iff (!rst_n)
        !is_sc |=> !rsp_valid_o);                                            // R8
    AST_EMPTY_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && !held) |=> (rsp_status_o[0] && !mem_we_o));               // R1
    AST_SNOOP_RACE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && snoop_valid_i &&
         snoop_addr_i[ADDR_W-1:GRAN_LG2] == req_addr_i[ADDR_W-1:GRAN_LG2])
        |=> rsp_status_o[0]);                                                // R6
    AST_PLAIN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> mem_we_o);                                                 // R10
endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_op_i = 2'd0;
    logic [31:0] req_addr_i = '0;
    logic        req_size_i = 1'b1;
    logic [63:0] req_wdata_i = '0;
    logic        snoop_valid_i = 1'b0;
    logic [31:0] snoop_addr_i = '0;
    logic        rsp_valid_o;
    logic [63:0] rsp_status_o;
    logic        mem_we_o;
    logic [7:0]  mem_be_o;
    logic [31:0] mem_addr_o;
    logic [63:0] mem_wdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit          m_held = 1'b0;
    logic [28:0] m_gran = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .req_valid_i(req_valid_i),
        .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_size_i(req_size_i),
        .req_wdata_i(req_wdata_i), .snoop_valid_i(snoop_valid_i),
        .snoop_addr_i(snoop_addr_i), .rsp_valid_o(rsp_valid_o),
        .rsp_status_o(rsp_status_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

    function automatic logic [28:0] gran(input logic [31:0] a);
        return a[31:3];
    endfunction

    function automatic logic [7:0] exp_be(input logic full, input logic [31:0] a);
        if (full) return 8'hFF;
        return a[2] ? 8'hF0 : 8'h0F;
    endfunction

    function automatic logic [63:0] exp_data(input logic full, input logic [63:0] d);
        if (full) return d;
        return {d[31:0], d[31:0]};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model, check registered outputs next negedge
    task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a,
                        input logic full, input logic [63:0] d,
                        input logic sv, input logic [31:0] sa,
                        input logic cl, input string tag);
        bit is_sc, snp, ok, we;
        req_valid_i = v; req_op_i = op; req_addr_i = a; req_size_i = full;
        req_wdata_i = d; snoop_valid_i = sv; snoop_addr_i = sa; clr_i = cl;
        is_sc = v && op == 2'd1;
        snp   = sv && m_held && gran(sa) == m_gran;
        ok    = is_sc && m_held && gran(a) == m_gran && !snp && !cl;
        we    = (v && (op == 2'd2 || op == 2'd3)) || ok;
        if (cl) m_held = 1'b0;
        else if (v && op == 2'd0) begin m_held = 1'b1; m_gran = gran(a); end
        else if (is_sc || snp) m_held = 1'b0;
        @(negedge clk);
        chk(tag, "rsp_valid", {63'd0, rsp_valid_o}, {63'd0, is_sc});
        if (is_sc) chk(tag, "status", rsp_status_o, ok ? 64'd0 : 64'd1);
        chk(tag, "mem_we", {63'd0, mem_we_o}, {63'd0, we});
        if (we) begin
            chk(tag, "mem_be", {56'd0, mem_be_o}, {56'd0, exp_be(full, a)});
            chk(tag, "mem_addr", {32'd0, mem_addr_o}, {32'd0, a & 32'hFFFF_FFF8});
            chk(tag, "mem_wdata", mem_wdata_o, exp_data(full, d));
        end
        req_valid_i = 1'b0; snoop_valid_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic lr(input logic [31:0] a, input string tag);
        step(1, 2'd0, a, 1, 64'd0, 0, 32'd0, 0, tag);
    endtask
    task automatic sc(input logic [31:0] a, input logic full, input logic [63:0] d,
                      input string tag);
        step(1, 2'd1, a, full, d, 0, 32'd0, 0, tag);
    endtask
    task automatic idle(input logic sv, input logic [31:0] sa, input logic cl,
                        input string tag);
        step(0, 2'd0, 32'd0, 1, 64'd0, sv, sa, cl, tag);
    endtask

    initial begin
        void'($urandom(32'd20231221));
        repeat (3) @(negedge clk);
        chk("R1", "reset rsp_valid", {63'd0, rsp_valid_o}, 64'd0);
        chk("R1", "reset mem_we", {63'd0, mem_we_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        sc(32'h100, 1, 64'h1111, "R1");                 // no reservation
        lr(32'h100, "R2"); sc(32'h104, 1, 64'hA5A5_0000_1234_5678, "R2");
        lr(32'h100, "R4"); sc(32'h108, 1, 64'h22, "R3"); sc(32'h100, 1, 64'h33, "R4");
        lr(32'h100, "R5"); idle(1, 32'h106, 0, "R5"); sc(32'h100, 1, 64'h44, "R5");
        lr(32'h100, "R5"); idle(1, 32'h200, 0, "R5"); sc(32'h100, 1, 64'h55, "R5");
        lr(32'h100, "R6");
        step(1, 2'd1, 32'h100, 1, 64'h66, 1, 32'h103, 0, "R6");
        lr(32'h100, "R7"); lr(32'h180, "R7"); sc(32'h100, 1, 64'h77, "R7");
        lr(32'h100, "R7"); lr(32'h180, "R7"); sc(32'h184, 1, 64'h78, "R7");
        lr(32'h104, "R9"); sc(32'h104, 0, 64'hDEAD_BEEF_CAFE_F00D, "R9");
        lr(32'h100, "R9"); sc(32'h100, 0, 64'h0123_4567_89AB_CDEF, "R9");
        lr(32'h100, "R10");
        step(1, 2'd2, 32'h100, 1, 64'h99, 0, 32'd0, 0, "R10");
        step(1, 2'd3, 32'h104, 0, 64'h98, 0, 32'd0, 0, "R10");
        sc(32'h100, 1, 64'h97, "R10");
        lr(32'h100, "R11"); idle(0, 32'd0, 1, "R11"); sc(32'h100, 1, 64'h10, "R11");
        step(1, 2'd0, 32'h100, 1, 64'd0, 0, 32'd0, 1, "R11");
        sc(32'h100, 1, 64'h11, "R11");
        lr(32'h100, "R11");
        step(1, 2'd1, 32'h100, 1, 64'h12, 0, 32'd0, 1, "R11");
        idle(0, 32'd0, 0, "R8");
        for (int i = 0; i < STEPS; i++) begin
            logic [31:0] a, sa;
            a  = 32'h400 + ($urandom % 32);
            sa = 32'h400 + ($urandom % 32);
            step(($urandom % 8) != 0, 2'($urandom % 4), a, 1'($urandom % 2),
                 {$urandom, $urandom}, ($urandom % 4) == 0, sa,
                 ($urandom % 20) == 0, "R8");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule